// File: doc/BRIEF.md
# Header Packet Framer with Link Retry

This block is the transmit half of a link layer. It takes 12-byte header packets from the protocol side over a valid/ready handshake. Each header gets a 3-bit sequence number and goes into a replay buffer. The block then sends it out as a byte stream: framing K-symbols, the header, a CRC-16 and a link control word. The partner's decoded link commands come back on a single command port:

- A positive acknowledge retires the buffered headers up to a given sequence number.
- A negative acknowledge starts a go-back replay. A retry K-symbol is sent first, then every unacknowledged header is resent.
- Credit tokens return receive-buffer space to the transmitter. The tokens are lettered and must arrive in strict rotation.

A new header leaves only when the block holds a credit and the replay window has room. Resent headers consume no credit. A credit token that arrives out of rotation, or one that would push the count above the maximum, is discarded and raises a sticky error flag.

Top module: `hp_link_tx`

## Requirements
- R1: After reset, `hdr_ready` is 1, `tx_valid` is 0 and `credit_err` is 0.
- R2: A header frame is 20 consecutive valid bytes, in this order:
  - three start symbols 0x5C, sent with `tx_is_k`=1;
  - one end-of-framing symbol 0xF7, sent with `tx_is_k`=1;
  - header bytes 0 to 11, where byte i is `hdr_data[8i+7:8i]`;
  - the CRC high byte, then the CRC low byte;
  - control word byte 0 = {4'b0, retry flag, seq[2:0]}, then control word byte 1 = 0x00.
  
  Every byte after the fourth has `tx_is_k`=0.
- R3: The CRC is a CRC-16 over the 12 header bytes. It uses polynomial 0x1021 and initial value 0xFFFF. Bytes are taken in order, most significant bit first, with no reflection and no final inversion.
- R4: New headers take sequence numbers 0, 1, 2 and so on, wrapping from 7 to 0. The retry flag is 0 on a first transmission.
- R5: Four credits are held after reset. Each accepted new header consumes one. With no credit held, `hdr_ready` stays 0 and nothing is sent.
- R6: At most four headers are unacknowledged. With four outstanding, `hdr_ready` stays 0.
- R7: A command with `lc_type`=0 and `lc_arg`=n is a positive acknowledge. It retires every outstanding header up to and including n, when n is outstanding. A value of n that is not outstanding is ignored.
- R8: A command with `lc_type`=1 is a negative acknowledge. While headers are outstanding, it causes the following, in order:
  - one K-symbol 0xFE;
  - every unacknowledged header resent in sequence order, with the retry flag set to 1.
  
  No new header is accepted until the replay ends. Resends consume no credit. With nothing outstanding, the command is ignored.
- R9: A command with `lc_type`=2 is a credit token, with its letter in `lc_arg[1:0]` (0=A, 1=B, 2=C, 3=D). A token in rotation order A, B, C, D, A and so on returns one credit.
- R10: A token that is out of rotation, or that would raise the credit count above four, sets `credit_err`. The flag stays set until reset. The token is discarded, and the expected letter does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hdr_valid | input | 1 | Header offered |
| hdr_ready | output | 1 | Header accepted on this edge when valid |
| hdr_data | input | 96 | Header bytes, byte 0 in bits 7:0 |
| lc_valid | input | 1 | Link command present |
| lc_type | input | 2 | 0 acknowledge, 1 negative acknowledge, 2 credit |
| lc_arg | input | 3 | Sequence number or credit letter |
| tx_valid | output | 1 | Output byte valid |
| tx_is_k | output | 1 | Output byte is a control symbol |
| tx_byte | output | 8 | Output byte |
| credit_err | output | 1 | Sticky credit rotation error |

## Verification
The hardest state to reach is a negative acknowledge that lands after a partial acknowledge, while some headers are still unretired. Only then does the replay start mid-window, and it must resend just the trailing headers. The bench gets there in several steps:
1. It withholds acknowledges while sending three headers.
2. It retires only the first of them.
3. It issues the negative acknowledge.
4. It checks that the retry symbol and exactly two resent frames follow.

Credit starvation combined with a full window is reached by sending four headers with no returned tokens. Acknowledges are then freed first and tokens afterwards, one of them deliberately out of rotation.

// File: rtl/hp_link_tx.sv
module hp_link_tx #(
  parameter int          SEQ_W     = 3,
  parameter int          RB_DEPTH  = 4,
  parameter int          CRD_MAX   = 4,
  parameter int          HDR_BYTES = 12,
  parameter logic [15:0] CRC_POLY  = 16'h1021,
  parameter logic [15:0] CRC_INIT  = 16'hFFFF,
  parameter logic [7:0]  K_SHP     = 8'h5C,
  parameter logic [7:0]  K_EPF     = 8'hF7,
  parameter logic [7:0]  K_LRTY    = 8'hFE
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   hdr_valid,
  output logic                   hdr_ready,
  input  logic [HDR_BYTES*8-1:0] hdr_data,
  input  logic                   lc_valid,
  input  logic [1:0]             lc_type,
  input  logic [SEQ_W-1:0]       lc_arg,
  output logic                   tx_valid,
  output logic                   tx_is_k,
  output logic [7:0]             tx_byte,
  output logic                   credit_err
);
  localparam int RB_AW     = $clog2(RB_DEPTH);
  localparam int CRD_W     = $clog2(CRD_MAX + 1);
  localparam int FRAME_LEN = HDR_BYTES + 8;
  localparam int CNT_W     = $clog2(FRAME_LEN);
  localparam int HDR_LO    = 4;
  localparam int CRC_POS   = HDR_LO + HDR_BYTES;

  typedef enum logic [1:0] {S_IDLE, S_LRTY, S_FRAME} state_t;

  state_t                 state;
  logic [HDR_BYTES*8-1:0] rbuf [RB_DEPTH];
  logic [SEQ_W-1:0]       next_seq, ack_seq, rp_seq, cur_seq, ack_n;
  logic                   cur_retry, replaying, retry_pend;
  logic [CRD_W-1:0]       credits, credits_n;
  logic [1:0]             exp_crd;
  logic [CNT_W-1:0]       cnt;

  function automatic logic [15:0] crc16(input logic [HDR_BYTES*8-1:0] d);
    logic [15:0] c;
    logic        fb;
    c = CRC_INIT;
    for (int i = 0; i < HDR_BYTES; i++)
      for (int b = 7; b >= 0; b--) begin
        fb = c[15] ^ d[8*i + b];
        c  = {c[14:0], 1'b0};
        if (fb) c = c ^ CRC_POLY;
      end
    return c;
  endfunction

  wire [SEQ_W-1:0] outst    = next_seq - ack_seq;
  wire [SEQ_W-1:0] good_off = lc_arg - ack_seq;
  wire good_ok  = lc_valid && lc_type == 2'd0 && good_off < outst;
  wire lc_bad   = lc_valid && lc_type == 2'd1 && outst != '0;
  wire crd_cmd  = lc_valid && lc_type == 2'd2;
  wire crd_hit  = crd_cmd && lc_arg[1:0] == exp_crd && credits < CRD_W'(CRD_MAX);
  wire crd_bad  = crd_cmd && !crd_hit;

  assign ack_n = good_ok ? lc_arg + SEQ_W'(1) : ack_seq;
  wire [SEQ_W-1:0] rp_off  = rp_seq - ack_n;
  wire [SEQ_W-1:0] outst_n = next_seq - ack_n;
  wire rp_more = rp_off < outst_n;

  assign hdr_ready = state == S_IDLE && !retry_pend && !replaying &&
                     credits != '0 && outst < SEQ_W'(RB_DEPTH);
  wire take = hdr_valid && hdr_ready;

  always_comb begin
    credits_n = credits;
    if (crd_hit) credits_n = credits_n + CRD_W'(1);
    if (take)    credits_n = credits_n - CRD_W'(1);
  end

  always_ff @(posedge clk)
    if (take) rbuf[next_seq[RB_AW-1:0]] <= hdr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      next_seq   <= '0;
      ack_seq    <= '0;
      rp_seq     <= '0;
      cur_seq    <= '0;
      cur_retry  <= 1'b0;
      replaying  <= 1'b0;
      retry_pend <= 1'b0;
      credits    <= CRD_W'(CRD_MAX);
      exp_crd    <= '0;
      cnt        <= '0;
      credit_err <= 1'b0;
    end else begin
      ack_seq <= ack_n;
      credits <= credits_n;
      if (crd_hit) exp_crd <= exp_crd + 2'd1;
      if (crd_bad) credit_err <= 1'b1;
      case (state)
        S_IDLE: begin
          if (retry_pend) begin
            state      <= S_LRTY;
            retry_pend <= 1'b0;
            replaying  <= 1'b1;
            rp_seq     <= ack_n;
          end else if (replaying) begin
            if (rp_more) begin
              cur_seq   <= rp_seq;
              cur_retry <= 1'b1;
              rp_seq    <= rp_seq + SEQ_W'(1);
              cnt       <= '0;
              state     <= S_FRAME;
            end else begin
              replaying <= 1'b0;
            end
          end else if (take) begin
            cur_seq   <= next_seq;
            cur_retry <= 1'b0;
            next_seq  <= next_seq + SEQ_W'(1);
            cnt       <= '0;
            state     <= S_FRAME;
          end
        end
        S_LRTY: state <= S_IDLE;
        default: begin
          if (cnt == CNT_W'(FRAME_LEN - 1)) state <= S_IDLE;
          else cnt <= cnt + CNT_W'(1);
        end
      endcase
      if (lc_bad) retry_pend <= 1'b1;
    end
  end

  wire [HDR_BYTES*8-1:0] cur_hdr = rbuf[cur_seq[RB_AW-1:0]];
  wire [15:0]            cur_crc = crc16(cur_hdr);

  always_comb begin
    logic [7:0] lcw0;
    int         c;
    lcw0           = '0;
    lcw0[SEQ_W-1:0] = cur_seq;
    lcw0[SEQ_W]     = cur_retry;
    c        = int'(cnt);
    tx_valid = 1'b0;
    tx_is_k  = 1'b0;
    tx_byte  = '0;
    if (state == S_LRTY) begin
      tx_valid = 1'b1;
      tx_is_k  = 1'b1;
      tx_byte  = K_LRTY;
    end else if (state == S_FRAME) begin
      tx_valid = 1'b1;
      if (c < 3) begin
        tx_is_k = 1'b1;
        tx_byte = K_SHP;
      end else if (c == 3) begin
        tx_is_k = 1'b1;
        tx_byte = K_EPF;
      end else if (c < CRC_POS) begin
        tx_byte = cur_hdr[8*(c - HDR_LO) +: 8];
      end else if (c == CRC_POS) begin
        tx_byte = cur_crc[15:8];
      end else if (c == CRC_POS + 1) begin
        tx_byte = cur_crc[7:0];
      end else if (c == CRC_POS + 2) begin
        tx_byte = lcw0;
      end
    end
  end
endmodule

// File: rtl/hp_link_tx_chk.sv
module hp_link_tx_chk #(
  parameter int         SEQ_W    = 3,
  parameter int         RB_DEPTH = 4,
  parameter int         CRD_MAX  = 4,
  parameter int         CRD_W    = 3,
  parameter logic [7:0] K_SHP    = 8'h5C,
  parameter logic [7:0] K_LRTY   = 8'hFE
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hdr_valid,
  input logic             hdr_ready,
  input logic             lc_valid,
  input logic [1:0]       lc_type,
  input logic [SEQ_W-1:0] lc_arg,
  input logic             tx_valid,
  input logic             tx_is_k,
  input logic [7:0]       tx_byte,
  input logic             credit_err,
  input logic [CRD_W-1:0] credits,
  input logic [1:0]       exp_crd,
  input logic [SEQ_W-1:0] next_seq,
  input logic [SEQ_W-1:0] ack_seq
);
  wire [SEQ_W-1:0] window = next_seq - ack_seq;

  p_frame_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid && hdr_ready |=> tx_valid && tx_is_k && tx_byte == K_SHP);

  p_window_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    window <= SEQ_W'(RB_DEPTH));

  p_credit_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    credits <= CRD_W'(CRD_MAX));

  p_lrty_blocks_new_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_is_k && tx_byte == K_LRTY |=> !hdr_ready);

  p_bad_letter_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
    lc_valid && lc_type == 2'd2 && lc_arg[1:0] != exp_crd |=> credit_err);

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    credit_err |=> credit_err);
endmodule

bind hp_link_tx hp_link_tx_chk #(
  .SEQ_W(SEQ_W), .RB_DEPTH(RB_DEPTH), .CRD_MAX(CRD_MAX), .CRD_W(CRD_W),
  .K_SHP(K_SHP), .K_LRTY(K_LRTY)
) i_chk (
  .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
  .lc_valid(lc_valid), .lc_type(lc_type), .lc_arg(lc_arg),
  .tx_valid(tx_valid), .tx_is_k(tx_is_k), .tx_byte(tx_byte),
  .credit_err(credit_err), .credits(credits), .exp_crd(exp_crd),
  .next_seq(next_seq), .ack_seq(ack_seq)
);

// File: tb/test_hp_link_tx.sv
module test_hp_link_tx;
  localparam int         CLK_PERIOD = 10;
  localparam logic [7:0] E_SHP  = 8'h5C;
  localparam logic [7:0] E_EPF  = 8'hF7;
  localparam logic [7:0] E_LRTY = 8'hFE;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hdr_valid = 1'b0;
  logic        hdr_ready;
  logic [95:0] hdr_data = '0;
  logic        lc_valid = 1'b0;
  logic [1:0]  lc_type = '0;
  logic [2:0]  lc_arg = '0;
  logic        tx_valid, tx_is_k, credit_err;
  logic [7:0]  tx_byte;

  int tests = 0;
  int fails = 0;
  logic [8:0] cap [0:1023];
  int cap_n = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hp_link_tx i_hp_link_tx (
    .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
    .hdr_data(hdr_data), .lc_valid(lc_valid), .lc_type(lc_type), .lc_arg(lc_arg),
    .tx_valid(tx_valid), .tx_is_k(tx_is_k), .tx_byte(tx_byte), .credit_err(credit_err)
  );

  always @(negedge clk)
    if (rst_n && tx_valid && cap_n < 1024) begin
      cap[cap_n] = {tx_is_k, tx_byte};
      cap_n++;
    end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [95:0] mk_hdr(input int k);
    logic [95:0] h;
    for (int i = 0; i < 12; i++) h[8*i +: 8] = 8'(k * 29 + i * 7 + 1);
    return h;
  endfunction

  function automatic logic [15:0] ref_crc(input logic [95:0] h);
    logic [15:0] c;
    c = 16'hFFFF;
    for (int i = 0; i < 12; i++)
      for (int b = 7; b >= 0; b--)
        if (c[15] ^ h[8*i + b]) c = {c[14:0], 1'b0} ^ 16'h1021;
        else c = {c[14:0], 1'b0};
    return c;
  endfunction

  task automatic send_hdr(input logic [95:0] h);
    @(negedge clk);
    hdr_valid = 1'b1;
    hdr_data  = h;
    while (!hdr_ready) @(negedge clk);
    @(negedge clk);
    hdr_valid = 1'b0;
    repeat (22) @(negedge clk);
  endtask

  task automatic lc(input logic [1:0] t, input logic [2:0] a);
    @(negedge clk);
    lc_valid = 1'b1;
    lc_type  = t;
    lc_arg   = a;
    @(negedge clk);
    lc_valid = 1'b0;
  endtask

  task automatic check_frame(input int base, input int seq, input bit retry,
                             input logic [95:0] h);
    logic [15:0] c;
    bit ok;
    c = ref_crc(h);
    ok = 1'b1;
    for (int i = 0; i < 3; i++) ok &= cap[base+i] == {1'b1, E_SHP};
    ok &= cap[base+3] == {1'b1, E_EPF};
    chk(ok, "R2", "framing symbols", int'(cap[base]), int'({1'b1, E_SHP}));
    ok = 1'b1;
    for (int i = 0; i < 12; i++) ok &= cap[base+4+i] == {1'b0, h[8*i +: 8]};
    chk(ok, "R2", "header bytes", int'(cap[base+4]), int'({1'b0, h[7:0]}));
    chk(cap[base+16] == {1'b0, c[15:8]} && cap[base+17] == {1'b0, c[7:0]}, "R3",
        "crc", int'({cap[base+16][7:0], cap[base+17][7:0]}), int'(c));
    chk(cap[base+18] == {1'b0, 4'b0, retry, 3'(seq)} && cap[base+19] == 9'h000,
        retry ? "R8" : "R4", "control word",
        int'(cap[base+18]), int'({1'b0, 4'b0, retry, 3'(seq)}));
  endtask

  task automatic t_reset_r1;
    chk(hdr_ready == 1'b1, "R1", "ready after reset", int'(hdr_ready), 1);
    chk(tx_valid == 1'b0, "R1", "tx_valid after reset", int'(tx_valid), 0);
    chk(credit_err == 1'b0, "R1", "credit_err after reset", int'(credit_err), 0);
  endtask

  task automatic t_single_frame_r2;
    int base;
    base = cap_n;
    send_hdr(mk_hdr(0));
    chk(cap_n - base == 20, "R2", "frame length", cap_n - base, 20);
    check_frame(base, 0, 1'b0, mk_hdr(0));
    lc(2'd0, 3'd0);
    lc(2'd2, 3'd0);
  endtask

  task automatic t_credit_window_r5;
    int base;
    for (int k = 1; k <= 4; k++) send_hdr(mk_hdr(k));
    @(negedge clk);
    hdr_valid = 1'b1;
    hdr_data  = mk_hdr(99);
    base = cap_n;
    repeat (5) @(negedge clk);
    chk(hdr_ready == 1'b0 && cap_n == base, "R6", "full window blocks",
        int'(hdr_ready), 0);
    hdr_valid = 1'b0;
    lc(2'd0, 3'd4);
    @(negedge clk);
    hdr_valid = 1'b1;
    base = cap_n;
    repeat (5) @(negedge clk);
    chk(hdr_ready == 1'b0 && cap_n == base, "R5", "no credit blocks",
        int'(hdr_ready), 0);
    hdr_valid = 1'b0;
    lc(2'd2, 3'd2);
    chk(credit_err == 1'b1, "R10", "out-of-order token flagged", int'(credit_err), 1);
    chk(hdr_ready == 1'b0, "R10", "out-of-order token discarded", int'(hdr_ready), 0);
    lc(2'd2, 3'd1);
    chk(hdr_ready == 1'b1, "R9", "in-order token returns credit", int'(hdr_ready), 1);
    lc(2'd2, 3'd2);
    lc(2'd2, 3'd3);
    lc(2'd2, 3'd0);
    chk(credit_err == 1'b1, "R10", "flag stays set", int'(credit_err), 1);
  endtask

  task automatic t_retry_r8;
    int base;
    send_hdr(mk_hdr(5));
    send_hdr(mk_hdr(6));
    send_hdr(mk_hdr(7));
    lc(2'd0, 3'd5);
    base = cap_n;
    lc(2'd1, 3'd0);
    repeat (60) @(negedge clk);
    chk(cap_n - base == 41, "R8", "replay byte count", cap_n - base, 41);
    chk(cap[base] == {1'b1, E_LRTY}, "R8", "retry symbol first",
        int'(cap[base]), int'({1'b1, E_LRTY}));
    check_frame(base + 1, 6, 1'b1, mk_hdr(6));
    check_frame(base + 21, 7, 1'b1, mk_hdr(7));
    lc(2'd0, 3'd7);
    chk(hdr_ready == 1'b1, "R8", "resends kept last credit", int'(hdr_ready), 1);
    lc(2'd2, 3'd1);
    lc(2'd2, 3'd2);
    lc(2'd2, 3'd3);
  endtask

  task automatic t_wrap_r4;
    int base;
    base = cap_n;
    send_hdr(mk_hdr(8));
    check_frame(base, 0, 1'b0, mk_hdr(8));
    lc(2'd0, 3'd0);
    lc(2'd2, 3'd0);
  endtask

  task automatic t_stale_ack_r7;
    int base;
    send_hdr(mk_hdr(9));
    lc(2'd0, 3'd5);
    base = cap_n;
    lc(2'd1, 3'd0);
    repeat (40) @(negedge clk);
    chk(cap_n - base == 21, "R7", "stale acknowledge ignored", cap_n - base, 21);
    chk(cap[base] == {1'b1, E_LRTY}, "R8", "retry symbol", int'(cap[base]),
        int'({1'b1, E_LRTY}));
    check_frame(base + 1, 1, 1'b1, mk_hdr(9));
    lc(2'd0, 3'd1);
    lc(2'd2, 3'd1);
  endtask

  task automatic t_idle_nak_r8;
    int base;
    base = cap_n;
    lc(2'd1, 3'd0);
    repeat (30) @(negedge clk);
    chk(cap_n == base, "R8", "negative acknowledge with none outstanding",
        cap_n - base, 0);
    chk(hdr_ready == 1'b1, "R8", "ready after ignored nak", int'(hdr_ready), 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_r1();
    t_single_frame_r2();
    t_credit_window_r5();
    t_retry_r8();
    t_wrap_r4();
    t_stale_ack_r7();
    t_idle_nak_r8();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule